// File: doc/BRIEF.md
# Shared cache performance counter unit

This block counts activity in a shared second-level cache. It holds a configurable number of 32-bit event counters and one 32-bit cycle counter, and software reaches all of them through a small word-addressed register bus. Event pulses arrive on an input vector. Each event counter carries a type value that picks the input line it counts. The cycle counter advances on every clock while it is running.

Software starts and stops all counting with one global run bit. Each counter also has its own enable. Every counter that wraps from all ones to zero raises a sticky overflow flag. Each flag has its own interrupt enable, and one level interrupt output combines them.

The event counters and their type values are reached indirectly: a select register names one counter, and a data window and a type window then access that counter. The cycle counter has its own direct register. In every mask register the cycle counter always uses bit 31.

Top module: `cache_perf_mon`

## Requirements
- R1: Bit 0 of the control register (word address 0) is the global run bit and can be read and written. While it is 0, no counter changes except through a software write.
- R2: Control bits 15:11 read back the number of event counters, not counting the cycle counter. Writes do not change them, and all other control bits read 0.
- R3: Count enables are set by writing ones to address 1 and cleared by writing ones to address 2. Zero bits have no effect. A read of either address returns the enable mask. Bit 31 is the cycle counter and bit n is event counter n. Bits for counters that do not exist read 0.
- R4: Interrupt enables follow the same rules, with the set register at address 3 and the clear register at address 4.
- R5: The overflow flags read at address 5. Writing a 1 clears the matching flag and writing a 0 leaves it alone. If a wrap and a clear hit the same flag in the same cycle, the flag ends up set.
- R6: Address 6 holds a 5-bit counter select. The event data window at address 7 reads and writes the selected counter. When the select is at or beyond the number of counters, window reads return 0 and window writes are ignored.
- R7: The type window at address 8 writes and reads the selected counter's type value, with the same rule for an out-of-range select. A running, enabled counter adds 1 in each cycle where event input [type] is high. A type at or beyond the number of event inputs never counts.
- R8: The cycle counter is read and written directly at address 9. It adds 1 on every clock while the run bit and enable bit 31 are both set.
- R9: A counter that wraps from 0xFFFFFFFF to 0 sets its overflow flag and keeps counting from 0.
- R10: A software write to a counter takes priority over an increment in the same cycle. The counter takes the written value, and that cycle sets no overflow flag.
- R11: irq_o is high exactly when some overflow flag and its interrupt enable are both set. It stays high until software clears the flag or the enable.
- R12: After reset every register, counter, flag and type value is 0 and irq_o is low. Read data is 0 for unused addresses and on write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read request |
| event_i | input | NUM_EVT | Event pulse inputs, one per event source |
| irq_o | output | 1 | Overflow interrupt, a level signal |

## Verification
The bench builds the unit with three event counters and five event inputs. Three counters leave bits 3 to 30 unimplemented, so the bench can write ones there and check that they read back as 0. It can also move the select to 5 and exercise the out-of-range window, and give one counter the type 9, a source that does not exist. Preloading counters and the cycle counter close to all ones makes wraps, the wrap-versus-clear race and the write-versus-increment race reachable in a few cycles.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int DW      = 32;
  localparam int AW      = 4;
  localparam int SEL_W   = 5;
  localparam int CYC_BIT = 31;
  localparam int RUN_BIT = 0;
  localparam int NUM_LSB = 11;
  localparam int NUM_W   = 5;

  typedef enum logic [AW-1:0] {
    A_CTRL    = 4'd0,
    A_CEN_SET = 4'd1,
    A_CEN_CLR = 4'd2,
    A_IEN_SET = 4'd3,
    A_IEN_CLR = 4'd4,
    A_OVF     = 4'd5,
    A_SEL     = 4'd6,
    A_EVDATA  = 4'd7,
    A_EVTYPE  = 4'd8,
    A_CYC     = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/cpm_counter.sv
module cpm_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (ld_i)  q <= ld_val_i;
    else if (inc_i) q <= q + 1'b1;
  end

  // a load in the same cycle suppresses the wrap
  assign wrap_o = inc_i & ~ld_i & (&q);
  assign cnt_o  = q;
endmodule

// File: rtl/cpm_mask_reg.sv
module cpm_mask_reg #(
  parameter int           W    = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= ((q & ~clr_i) | set_i) & IMPL;
  end

  assign q_o = q;
endmodule

// File: rtl/cpm_evt_sel.sv
module cpm_evt_sel #(
  parameter int NUM_EVT = 8,
  parameter int TW      = 8
) (
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [TW-1:0]      type_i,
  output logic               hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int j = 0; j < NUM_EVT; j++) begin
      if (type_i == TW'(j)) hit_o = evt_i[j];
    end
  end
endmodule

// File: rtl/cache_perf_mon.sv
module cache_perf_mon
  import cpm_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 8,
  parameter int TYPE_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [3:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_EVT-1:0] event_i,
  output logic               irq_o
);
  localparam logic [DW-1:0] IMPL =
    (DW'(1) << CYC_BIT) | ((DW'(1) << NUM_CNT) - DW'(1));

  reg_addr_e addr_e;
  logic wr_en, rd_en;
  logic wr_ctrl, wr_sel, wr_evdata, wr_evtype, wr_cyc;
  logic [DW-1:0] cen_set, cen_clr, ien_set, ien_clr, ovf_set, ovf_clr;

  assign addr_e    = reg_addr_e'(addr_i);
  assign wr_en     = req_i & we_i;
  assign rd_en     = req_i & ~we_i;
  assign wr_ctrl   = wr_en && addr_e == A_CTRL;
  assign wr_sel    = wr_en && addr_e == A_SEL;
  assign wr_evdata = wr_en && addr_e == A_EVDATA;
  assign wr_evtype = wr_en && addr_e == A_EVTYPE;
  assign wr_cyc    = wr_en && addr_e == A_CYC;
  assign cen_set   = (wr_en && addr_e == A_CEN_SET) ? wdata_i : '0;
  assign cen_clr   = (wr_en && addr_e == A_CEN_CLR) ? wdata_i : '0;
  assign ien_set   = (wr_en && addr_e == A_IEN_SET) ? wdata_i : '0;
  assign ien_clr   = (wr_en && addr_e == A_IEN_CLR) ? wdata_i : '0;
  assign ovf_clr   = (wr_en && addr_e == A_OVF)     ? wdata_i : '0;

  // control and select
  logic             run_q;
  logic [SEL_W-1:0] sel_q;
  logic             sel_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      sel_q <= '0;
    end else begin
      if (wr_ctrl) run_q <= wdata_i[RUN_BIT];
      if (wr_sel)  sel_q <= wdata_i[SEL_W-1:0];
    end
  end

  assign sel_ok = sel_q < SEL_W'(NUM_CNT);

  // mask registers
  logic [DW-1:0] cen_q, ien_q, ovf_q;

  cpm_mask_reg #(.W(DW), .IMPL(IMPL)) u_cen (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(cen_set), .clr_i(cen_clr), .q_o(cen_q));
  cpm_mask_reg #(.W(DW), .IMPL(IMPL)) u_ien (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ien_set), .clr_i(ien_clr), .q_o(ien_q));
  cpm_mask_reg #(.W(DW), .IMPL(IMPL)) u_ovf (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ovf_set), .clr_i(ovf_clr), .q_o(ovf_q));

  // event counters
  logic [DW-1:0]     evt_cnt [NUM_CNT];
  logic [TYPE_W-1:0] type_q  [NUM_CNT];
  logic [NUM_CNT-1:0] evt_wrap;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_evt
    logic hit;
    logic sel_me;

    assign sel_me = sel_q == SEL_W'(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 type_q[i] <= '0;
      else if (wr_evtype & sel_me) type_q[i] <= wdata_i[TYPE_W-1:0];
    end

    cpm_evt_sel #(.NUM_EVT(NUM_EVT), .TW(TYPE_W)) u_sel (
      .evt_i (event_i),
      .type_i(type_q[i]),
      .hit_o (hit)
    );

    cpm_counter #(.W(DW)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (run_q & cen_q[i] & hit),
      .ld_i    (wr_evdata & sel_me),
      .ld_val_i(wdata_i),
      .cnt_o   (evt_cnt[i]),
      .wrap_o  (evt_wrap[i])
    );
  end

  // cycle counter
  logic [DW-1:0] cyc_cnt;
  logic          cyc_wrap;

  cpm_counter #(.W(DW)) u_cyc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (run_q & cen_q[CYC_BIT]),
    .ld_i    (wr_cyc),
    .ld_val_i(wdata_i),
    .cnt_o   (cyc_cnt),
    .wrap_o  (cyc_wrap)
  );

  always_comb begin
    ovf_set                = '0;
    ovf_set[NUM_CNT-1:0]   = evt_wrap;
    ovf_set[CYC_BIT]       = cyc_wrap;
  end

  // read path
  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (addr_e)
      A_CTRL: begin
        rd_mux[RUN_BIT]              = run_q;
        rd_mux[NUM_LSB +: NUM_W]     = NUM_W'(NUM_CNT);
      end
      A_CEN_SET, A_CEN_CLR: rd_mux = cen_q;
      A_IEN_SET, A_IEN_CLR: rd_mux = ien_q;
      A_OVF:                rd_mux = ovf_q;
      A_SEL:                rd_mux[SEL_W-1:0] = sel_q;
      A_EVDATA: begin
        for (int i = 0; i < NUM_CNT; i++)
          if (sel_ok && sel_q == SEL_W'(i)) rd_mux = evt_cnt[i];
      end
      A_EVTYPE: begin
        for (int i = 0; i < NUM_CNT; i++)
          if (sel_ok && sel_q == SEL_W'(i)) rd_mux[TYPE_W-1:0] = type_q[i];
      end
      A_CYC:   rd_mux = cyc_cnt;
      default: rd_mux = '0;
    endcase
  end

  assign rdata_o = rd_en ? rd_mux : '0;
  assign irq_o   = |(ovf_q & ien_q);
endmodule

// File: rtl/cpm_checker.sv
module cpm_checker #(
  parameter int NUM_CNT = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [3:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        irq_o,
  input logic        run_q,
  input logic        cen_cyc,
  input logic [31:0] cyc_q,
  input logic [31:0] ovf_q,
  input logic [31:0] ien_q
);
  logic wr_cyc, cyc_counting;
  assign wr_cyc       = req_i && we_i && addr_i == 4'd9;
  assign cyc_counting = run_q && cen_cyc;

  AST_CTRL_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 4'd0) |->
      (rdata_o[31:16] == 16'h0 && rdata_o[15:11] == 5'(NUM_CNT) &&
       rdata_o[10:1] == 10'h0 && rdata_o[0] == run_q)); // R2

  AST_CYC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !wr_cyc) |=> cyc_q == $past(cyc_q)); // R1

  AST_CYC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_counting && cyc_q == 32'hFFFF_FFFF && !wr_cyc) |=> (ovf_q[31] && cyc_q == 32'h0)); // R9

  AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 4'd5 && wdata_i[31] &&
     !(cyc_counting && cyc_q == 32'hFFFF_FFFF)) |=> !ovf_q[31]); // R5

  AST_SW_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cyc |=> (cyc_q == $past(wdata_i) && $stable(ovf_q[31]))); // R10

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ovf_q & ien_q) == 32'h0) |-> !irq_o); // R11
endmodule

bind cache_perf_mon cpm_checker #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .run_q  (run_q),
  .cen_cyc(cen_q[31]),
  .cyc_q  (cyc_cnt),
  .ovf_q  (ovf_q),
  .ien_q  (ien_q)
);

// File: tb/tb_cache_perf_mon.sv
module tb_cache_perf_mon;
  localparam int NC = 3;
  localparam int NE = 5;
  localparam logic [31:0] IMPL = 32'h8000_0007;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NE-1:0] ev = '0;
  logic irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cache_perf_mon #(.NUM_CNT(NC), .NUM_EVT(NE), .TYPE_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .event_i(ev), .irq_o(irq));

  // behavioural reference model
  logic [31:0] m_cnt [NC];
  int          m_typ [NC];
  logic [31:0] m_cyc, m_cen, m_ien, m_ovf;
  bit          m_en;
  int          m_sel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin m_cnt[i] = 0; m_typ[i] = 0; end
      m_cyc = 0; m_cen = 0; m_ien = 0; m_ovf = 0; m_en = 0; m_sel = 0;
    end else begin
      bit w;
      logic [31:0] wraps;
      w = req && we;
      wraps = 0;
      for (int i = 0; i < NC; i++) begin
        bit hit;
        hit = 0;
        for (int j = 0; j < NE; j++) if (m_typ[i] == j) hit = ev[j];
        if (w && addr == 7 && m_sel == i) m_cnt[i] = wdata;
        else if (m_en && m_cen[i] && hit) begin
          if (m_cnt[i] == 32'hFFFF_FFFF) wraps[i] = 1;
          m_cnt[i] = m_cnt[i] + 1;
        end
      end
      if (w && addr == 9) m_cyc = wdata;
      else if (m_en && m_cen[31]) begin
        if (m_cyc == 32'hFFFF_FFFF) wraps[31] = 1;
        m_cyc = m_cyc + 1;
      end
      if (w) begin
        case (addr)
          0: m_en = wdata[0];
          1: m_cen = (m_cen | wdata) & IMPL;
          2: m_cen = m_cen & ~wdata;
          3: m_ien = (m_ien | wdata) & IMPL;
          4: m_ien = m_ien & ~wdata;
          6: m_sel = int'(wdata[4:0]);
          8: if (m_sel < NC) m_typ[m_sel] = int'(wdata[7:0]);
          default: ;
        endcase
      end
      m_ovf = ((m_ovf & ~((w && addr == 5) ? wdata : 32'h0)) | wraps) & IMPL;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    logic [31:0] r;
    r = 0;
    case (a)
      0: r = {16'h0, 5'(NC), 10'h0, m_en};
      1, 2: r = m_cen;
      3, 4: r = m_ien;
      5: r = m_ovf;
      6: r = 32'(m_sel);
      7: r = (m_sel < NC) ? m_cnt[m_sel] : 32'h0;
      8: r = (m_sel < NC) ? 32'(m_typ[m_sel] & 8'hFF) : 32'h0;
      9: r = m_cyc;
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic step(input bit r, input bit w, input logic [3:0] a,
                      input logic [31:0] d, input logic [NE-1:0] e, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; ev = e;
    #1;
    exp = (r && !w) ? exp_rd(a) : 32'h0;
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d rdata=%h expected=%h", tag, a, rdata, exp);
    end
    total++;
    if (irq !== (|(m_ovf & m_ien))) begin
      bad++;
      $display("FAIL R11 irq=%b expected=%b", irq, |(m_ovf & m_ien));
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [NE-1:0] e, input string tag);
    step(1, 1, a, d, e, tag);
  endtask

  task automatic rd(input logic [3:0] a, input logic [NE-1:0] e, input string tag);
    step(1, 0, a, 32'h0, e, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12: reset state on every address
    for (int a = 0; a < 16; a++) rd(4'(a), '0, "R12");
    // R2: count field read-only
    wr(0, 32'hFFFF_FFFF, '0, "R2");
    rd(0, '0, "R2");
    wr(0, 32'h0, '0, "R1");
    // R3: enables set/clear, unimplemented bits read zero
    wr(1, 32'hFFFF_FFFF, '0, "R3");
    rd(1, '0, "R3");
    wr(2, 32'h0000_0002, '0, "R3");
    rd(2, '0, "R3");
    wr(1, 32'h0, '0, "R3");
    rd(1, '0, "R3");
    wr(1, 32'h0000_0002, '0, "R3");
    // R7: types through select
    wr(6, 0, '0, "R6"); wr(8, 2, '0, "R7"); rd(8, '0, "R7");
    wr(6, 1, '0, "R6"); wr(8, 4, '0, "R7");
    wr(6, 2, '0, "R6"); wr(8, 9, '0, "R7"); rd(8, '0, "R7");
    // R1: global run off, nothing counts
    for (int k = 0; k < 10; k++) rd(7, NE'($urandom_range(0, 31)), "R1");
    rd(9, 5'h1F, "R1");
    // run on, random events, rotate select
    wr(0, 1, '0, "R1");
    for (int k = 0; k < 36; k++) begin
      if (k % 12 == 0) wr(6, 32'(k / 12), '0, "R6");
      else rd(7, NE'($urandom_range(0, 31)), "R7");
    end
    rd(9, '0, "R8");
    rd(9, '0, "R8");
    // R9: event counter wrap
    wr(6, 1, '0, "R6");
    wr(7, 32'hFFFF_FFFE, 5'h10, "R9");
    for (int k = 0; k < 4; k++) rd(5, 5'h10, "R9");
    rd(7, '0, "R9");
    wr(3, 32'h0000_0002, '0, "R4");
    rd(3, '0, "R4");
    rd(4, '0, "R11");
    // R5: zero write no effect, one write clears
    wr(5, 32'h0, '0, "R5");
    rd(5, '0, "R5");
    wr(5, 32'h0000_0002, '0, "R5");
    rd(5, '0, "R5");
    // R10: write beats increment
    wr(7, 32'h0000_1234, 5'h10, "R10");
    rd(7, '0, "R10");
    wr(7, 32'hFFFF_FFFF, 5'h10, "R10");
    rd(5, '0, "R10");
    rd(7, '0, "R10");
    // R5: wrap and clear in same cycle, set wins
    wr(7, 32'hFFFF_FFFF, '0, "R5");
    wr(5, 32'h0000_0002, 5'h10, "R5");
    rd(5, '0, "R5");
    rd(7, '0, "R5");
    // R8/R9: cycle counter direct access and wrap
    wr(9, 32'hFFFF_FFFD, '0, "R8");
    for (int k = 0; k < 4; k++) rd(9, '0, "R9");
    rd(5, '0, "R9");
    wr(3, 32'h8000_0000, '0, "R4");
    rd(5, '0, "R11");
    wr(5, 32'hFFFF_FFFF, '0, "R5");
    rd(5, '0, "R11");
    wr(4, 32'hFFFF_FFFF, '0, "R4");
    rd(3, '0, "R4");
    // R6: out-of-range select
    wr(6, 5, '0, "R6");
    rd(6, '0, "R6");
    rd(7, '0, "R6");
    wr(7, 32'h55, '0, "R6");
    rd(7, '0, "R6");
    wr(8, 3, '0, "R6");
    rd(8, '0, "R6");
    for (int s = 0; s < NC; s++) begin
      wr(6, 32'(s), '0, "R6");
      rd(7, '0, "R6");
      rd(8, '0, "R7");
    end
    // R3: disable all, counters freeze
    wr(2, 32'hFFFF_FFFF, '0, "R3");
    for (int k = 0; k < 6; k++) rd(9, NE'($urandom_range(0, 31)), "R3");
    wr(6, 0, '0, "R6");
    for (int k = 0; k < 6; k++) rd(7, 5'h1F, "R3");
    // R1: run off again
    wr(1, 32'hFFFF_FFFF, '0, "R3");
    wr(0, 0, '0, "R1");
    for (int k = 0; k < 6; k++) rd(9, 5'h1F, "R1");
    rd(7, '0, "R1");
    step(0, 0, 0, 0, '0, "R12");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule